// File: doc/BRIEF.md
# Four-Bit Universal Shift Register

This block holds a four-stage register, D3 (most significant) down to D0. On each rising clock edge it either captures a four-bit parallel word or shifts right by one place, depending on a mode input. When shifting, the serial input enters D3, and every other stage takes the value of the stage above it. An active-low clear empties the register at once, without waiting for the clock.

The stage values leave the block on a data bus that carries a drive-enable. When the active-low output enable is high, the bus is released, which stands for high impedance: the enable is low and the data lines read zero. A separate cascade output always drives the value of D0, whatever the output enable is doing. This lets the register be chained to a neighbour, or rotate its own contents when the cascade is wired back to the serial input.

The register is built around two named operations, LOAD and SHIFT, and a two-state output driver, DRV_OFF and DRV_ON. The operation is picked on every edge from the mode input: mode 1 selects the transition to LOAD and mode 0 selects the transition to SHIFT. The driver state follows the output enable: high selects DRV_OFF and low selects DRV_ON. Clear overrides both operations.

Top module: `quad_univ_shreg`

## Requirements
- R1: While clr_n is 0, every stage, every bus_q line and cascade read 0 without any clock edge. Clear also wins over a load or shift at an edge.
- R2: With load_mode = 1 at a rising edge, stage Di takes par_in[i] (par_in[3] goes to D3, par_in[0] goes to D0).
- R3: With load_mode = 0 at a rising edge, D3 takes ser_in and Di takes the old D(i+1) for i = 2..0.
- R4: Between rising edges the stages hold their value, whatever par_in, ser_in and load_mode do.
- R5: cascade always equals D0, whether the bus is enabled or not.
- R6: With oe_n = 1, bus_en is 0 and bus_q is 0000 (high impedance). With oe_n = 0, bus_en is 1 and bus_q[i] = Di.
- R7: Loading and shifting continue while the bus is disabled, and the contents show up once oe_n returns to 0.
- R8: With ser_in driven from cascade, each shift rotates the contents by one place: 0101 becomes 1010, then 0101 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge is active |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_mode | input | 1 | 1 = parallel load, 0 = serial shift |
| par_in | input | 4 | Parallel data word, bit i goes to stage Di |
| ser_in | input | 1 | Serial data that enters D3 |
| oe_n | input | 1 | Output enable for the stage bus, active low |
| bus_q | output | 4 | Stage values D3..D0; reads 0 when released |
| bus_en | output | 1 | Drive-enable of bus_q; 0 means high impedance |
| cascade | output | 1 | Copy of D0, always driven |

## Verification
A wrong stage value reaches the ports in the same cycle. D0 shows on cascade at all times, and the whole register shows on bus_q whenever it is enabled. Errors in the upper stages also reach cascade, one stage per shift, so a corrupted D3 appears there after at most three further shifts. A fault in the output driver shows as soon as oe_n toggles, with no clock edge needed. A fault in the clear path shows the instant clr_n falls.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

    // Operation applied at a rising clock edge
    typedef enum logic {
        OP_SHIFT = 1'b0,
        OP_LOAD  = 1'b1
    } op_e;

    // State of the stage-bus driver
    typedef enum logic {
        DRV_OFF = 1'b0,
        DRV_ON  = 1'b1
    } drv_e;

endpackage

// File: rtl/shreg_mode_dec.sv
module shreg_mode_dec
    import shreg_pkg::*;
(
    input  logic load_mode,
    input  logic oe_n,
    output op_e  op,
    output drv_e drv
);

    // Operation select: mode 1 means LOAD, mode 0 means SHIFT
    always_comb begin
        if (load_mode) begin
            op = OP_LOAD;
        end else begin
            op = OP_SHIFT;
        end
    end

    // Driver select: active-low enable
    always_comb begin
        if (oe_n) begin
            drv = DRV_OFF;
        end else begin
            drv = DRV_ON;
        end
    end

endmodule

// File: rtl/shreg_core.sv
module shreg_core
    import shreg_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  op_e          op,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    output logic [W-1:0] stage
);

    localparam int TOP = W - 1;

    logic [W-1:0] shift_nxt;
    logic [W-1:0] stage_nxt;

    // Shift network: the top stage takes the serial bit, every other stage takes its upper neighbour
    for (genvar i = 0; i < W; i++) begin : g_shift
        if (i == TOP) begin : g_top
            assign shift_nxt[i] = ser_in;
        end else begin : g_mid
            assign shift_nxt[i] = stage[i+1];
        end
    end

    always_comb begin
        unique case (op)
            OP_LOAD:  stage_nxt = par_in;
            OP_SHIFT: stage_nxt = shift_nxt;
            default:  stage_nxt = stage;
        endcase
    end

    // Clear is asynchronous and wins over both operations
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            stage <= '0;
        end else begin
            stage <= stage_nxt;
        end
    end

endmodule

// File: rtl/shreg_outdrv.sv
module shreg_outdrv
    import shreg_pkg::*;
#(
    parameter int W = 4
) (
    input  drv_e         drv,
    input  logic [W-1:0] stage,
    output logic [W-1:0] bus_q,
    output logic         bus_en,
    output logic         cascade
);

    always_comb begin
        unique case (drv)
            DRV_ON: begin
                bus_q  = stage;
                bus_en = 1'b1;
            end
            DRV_OFF: begin
                bus_q  = '0;
                bus_en = 1'b0;
            end
            default: begin
                bus_q  = '0;
                bus_en = 1'b0;
            end
        endcase
    end

    // Cascade copy of the lowest stage; the driver state has no effect on it
    assign cascade = stage[0];

endmodule

// File: rtl/quad_univ_shreg.sv
module quad_univ_shreg
    import shreg_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic         load_mode,
    input  logic [W-1:0] par_in,
    input  logic         ser_in,
    input  logic         oe_n,
    output logic [W-1:0] bus_q,
    output logic         bus_en,
    output logic         cascade
);

    op_e          op;
    drv_e         drv;
    logic [W-1:0] stage;

    shreg_mode_dec u_dec (
        .load_mode (load_mode),
        .oe_n      (oe_n),
        .op        (op),
        .drv       (drv)
    );

    shreg_core #(.W(W)) u_core (
        .clk    (clk),
        .clr_n  (clr_n),
        .op     (op),
        .par_in (par_in),
        .ser_in (ser_in),
        .stage  (stage)
    );

    shreg_outdrv #(.W(W)) u_drv (
        .drv     (drv),
        .stage   (stage),
        .bus_q   (bus_q),
        .bus_en  (bus_en),
        .cascade (cascade)
    );

endmodule

// File: rtl/quad_univ_shreg_chk.sv
module quad_univ_shreg_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         clr_n,
    input logic         load_mode,
    input logic [W-1:0] par_in,
    input logic         ser_in,
    input logic         oe_n,
    input logic [W-1:0] bus_q,
    input logic         bus_en,
    input logic         cascade,
    input logic [W-1:0] stage
);

    // R1: a held clear keeps everything at zero
    assert_clear_zero_R1: assert property (@(posedge clk)
        !clr_n |-> (stage == '0 && cascade == 1'b0 && bus_q == '0));

    // R2: a load captures the parallel word
    assert_load_capture_R2: assert property (@(posedge clk) disable iff (!clr_n)
        load_mode |=> stage == $past(par_in));

    // R3: a shift moves the serial bit in at the top
    assert_shift_move_R3: assert property (@(posedge clk) disable iff (!clr_n)
        !load_mode |=> stage == {$past(ser_in), $past(stage[W-1:1])});

    // R5: cascade agrees with the lowest bus line whenever the bus is driven
    assert_cascade_match_R5: assert property (@(posedge clk) disable iff (!clr_n)
        bus_en |-> cascade == bus_q[0]);

    // R6: a released bus drives nothing
    assert_bus_released_R6: assert property (@(posedge clk) disable iff (!clr_n)
        oe_n |-> (!bus_en && bus_q == '0));

    // R6: an enabled bus shows the stages
    assert_bus_driven_R6: assert property (@(posedge clk) disable iff (!clr_n)
        !oe_n |-> (bus_en && bus_q == stage));

endmodule

bind quad_univ_shreg quad_univ_shreg_chk #(.W(W)) u_chk (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_mode (load_mode),
    .par_in    (par_in),
    .ser_in    (ser_in),
    .oe_n      (oe_n),
    .bus_q     (bus_q),
    .bus_en    (bus_en),
    .cascade   (cascade),
    .stage     (stage)
);

// File: tb/sim_quad_univ_shreg.sv
`timescale 1ns/1ps
module sim_quad_univ_shreg;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         clr_n = 1'b0;
    logic         load_mode = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_reg = 1'b0;
    logic         rotate = 1'b0;
    logic         oe_n = 1'b0;
    logic [W-1:0] bus_q;
    logic         bus_en;
    logic         cascade;
    logic         ser_in;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    // When rotating, the serial input is fed from cascade
    assign ser_in = rotate ? cascade : ser_reg;

    always #4 clk = ~clk;

    quad_univ_shreg #(.W(W)) u0 (
        .clk       (clk),
        .clr_n     (clr_n),
        .load_mode (load_mode),
        .par_in    (par_in),
        .ser_in    (ser_in),
        .oe_n      (oe_n),
        .bus_q     (bus_q),
        .bus_en    (bus_en),
        .cascade   (cascade)
    );

    typedef struct packed {
        logic       ld;
        logic [3:0] par;
        logic       ser;
        logic       oen;
        logic [3:0] exp;
    } vec_t;

    // Vectors applied after a clear; exp is the stage content D3..D0 after the edge
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 4'h0, 1'b0, 1'b0, 4'b0000},
        '{1'b0, 4'h0, 1'b1, 1'b0, 4'b1000},
        '{1'b0, 4'h0, 1'b0, 1'b0, 4'b0100},
        '{1'b0, 4'h0, 1'b1, 1'b0, 4'b1010},
        '{1'b0, 4'h0, 1'b0, 1'b0, 4'b0101},
        '{1'b0, 4'h0, 1'b1, 1'b0, 4'b1010},
        '{1'b1, 4'h5, 1'b0, 1'b0, 4'b0101},
        '{1'b1, 4'hA, 1'b0, 1'b0, 4'b1010},
        '{1'b0, 4'h0, 1'b1, 1'b0, 4'b1101},
        '{1'b1, 4'hF, 1'b0, 1'b1, 4'b1111},
        '{1'b0, 4'h0, 1'b0, 1'b1, 4'b0111},
        '{1'b0, 4'h0, 1'b0, 1'b0, 4'b0011},
        '{1'b1, 4'h0, 1'b1, 1'b0, 4'b0000}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Checks all outputs against a stage content, following R5 and R6
    task automatic chk_all(input string tag, input logic [3:0] exp, input logic oen);
        chk({tag, " cascade R5"}, {7'd0, cascade}, {7'd0, exp[0]});
        chk({tag, " bus_en R6"}, {7'd0, bus_en}, {7'd0, ~oen});
        chk({tag, " bus_q"}, {4'd0, bus_q}, oen ? 8'd0 : {4'd0, exp});
    endtask

    task automatic step(input logic ld, input logic [3:0] par, input logic ser, input logic oen);
        @(negedge clk);
        load_mode = ld;
        par_in = par;
        ser_reg = ser;
        oe_n = oen;
        @(posedge clk);
        #2;
    endtask

    initial begin
        // Reset state (R1)
        #1;
        chk_all("reset R1", 4'b0000, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        clr_n = 1'b1;

        // Vector walk (R2, R3, R7)
        for (int k = 0; k < NV; k++) begin
            step(VEC[k].ld, VEC[k].par, VEC[k].ser, VEC[k].oen);
            if (VEC[k].oen)
                chk_all("vector R7", VEC[k].exp, VEC[k].oen);
            else if (VEC[k].ld)
                chk_all("vector R2", VEC[k].exp, VEC[k].oen);
            else
                chk_all("vector R3", VEC[k].exp, VEC[k].oen);
        end

        // R4: inputs move between edges, stages hold
        step(1'b1, 4'b1001, 1'b0, 1'b0);
        @(negedge clk);
        load_mode = 1'b0;
        par_in = 4'b0110;
        ser_reg = 1'b1;
        #1;
        load_mode = 1'b1;
        #1;
        chk_all("hold R4", 4'b1001, 1'b0);

        // R6: the bus releases and returns without a clock edge
        oe_n = 1'b1;
        #1;
        chk_all("release R6", 4'b1001, 1'b1);
        oe_n = 1'b0;
        #1;
        chk_all("restore R6", 4'b1001, 1'b0);

        // R1: asynchronous clear between edges, then held against a load
        step(1'b1, 4'b1111, 1'b0, 1'b0);
        chk_all("preload R2", 4'b1111, 1'b0);
        @(negedge clk);
        #1;
        clr_n = 1'b0;
        #1;
        chk_all("async clear R1", 4'b0000, 1'b0);
        load_mode = 1'b1;
        par_in = 4'b1111;
        @(posedge clk);
        #2;
        chk_all("clear priority R1", 4'b0000, 1'b0);
        @(negedge clk);
        clr_n = 1'b1;

        // R8: rotation with cascade fed back
        step(1'b1, 4'b0101, 1'b0, 1'b0);
        chk_all("rotate load R8", 4'b0101, 1'b0);
        @(negedge clk);
        rotate = 1'b1;
        step(1'b0, 4'b0000, 1'b0, 1'b0);
        chk_all("rotate one R8", 4'b1010, 1'b0);
        step(1'b0, 4'b0000, 1'b0, 1'b0);
        chk_all("rotate two R8", 4'b0101, 1'b0);
        step(1'b0, 4'b0000, 1'b0, 1'b1);
        chk_all("rotate hidden R8", 4'b1010, 1'b1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule